// File: doc/BRIEF.md
# Multiprocessor UART Receiver with Address Filter

This block receives asynchronous serial frames with eight or nine data bits, least significant bit first, on a line sampled at sixteen ticks per bit. An external tick pulse sets the rate. Each bit is decided by a majority vote of three mid-bit samples. A start bit that fails this vote is dropped, and a stop bit that reads low sets a sticky framing-error flag.

For multi-drop buses the receiver can filter frames by address. A slave address register and a mask register define a "given" address, where mask zeros are don't-care bits, and a "broadcast" address, equal to address OR mask, where zeros of that OR are don't-care bits. When filtering is enabled, the receive flag is raised and the byte is loaded only for frames that hit either pattern. In nine-bit mode the frame must also carry a ninth bit of 1. The framing-error flag and the nine-bit mode bit share one register position. A select input decides which of the two that position reads and writes.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset rx_flag, fe_flag, rx_data and rx_bit9 are 0, the mode is eight-bit, and pos7_rd reads 0 with either select.
- R2: Each bit lasts 16 ticks. Its value is the majority of the samples taken at ticks 7, 8 and 9. A start bit whose majority is high is discarded and the receiver returns to idle without touching any output.
- R3: With filtering enabled in nine-bit mode, a frame whose ninth bit is 0 never raises rx_flag and never changes rx_data.
- R4: A byte matches the given address when (byte AND mask) equals (address AND mask). With address 0xC0 and mask 0xFD, byte 0xC2 is accepted and byte 0xC1 is rejected.
- R5: A byte matches the broadcast address when every bit set in (address OR mask) is also set in the byte.
- R6: In eight-bit mode with filtering enabled, rx_flag rises only when the stop bit is valid and the byte matches the given or the broadcast address.
- R7: With address and mask both 0 and filtering enabled, every byte is accepted.
- R8: A low stop bit sets fe_flag and does not raise rx_flag. fe_flag stays set until software writes 0 through the shared position with fe_sel = 1. Writing 1 there does not clear it.
- R9: The shared position (pos7_we, pos7_wd, pos7_rd) reaches fe_flag when fe_sel = 1 and the mode bit when fe_sel = 0. Mode bit value 1 selects nine-bit frames.
- R10: With filtering disabled, every frame with a valid stop bit raises rx_flag and loads rx_data and rx_bit9. rx_bit9 is 0 in eight-bit mode. A pulse on rx_flag_clr lowers rx_flag. A new acceptance in the same cycle takes precedence over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling tick, 16 per bit |
| rxd | input | 1 | Serial line, idle high |
| addr_en | input | 1 | Address filtering enable |
| fe_sel | input | 1 | Shared position select: 1 = framing error, 0 = mode bit |
| pos7_we | input | 1 | Write strobe for the shared position |
| pos7_wd | input | 1 | Write data for the shared position |
| pos7_rd | output | 1 | Read value of the shared position |
| slave_addr | input | 8 | Slave address register |
| addr_mask | input | 8 | Address mask register |
| rx_flag_clr | input | 1 | Clear pulse for rx_flag |
| rx_data | output | 8 | Last accepted byte |
| rx_bit9 | output | 1 | Ninth bit of the last accepted frame |
| rx_flag | output | 1 | Receive flag |
| fe_flag | output | 1 | Framing-error flag |

## Verification
Frame results register on the clock edge of tick 15 of the stop bit. rx_flag, fe_flag, rx_data and rx_bit9 therefore change in that one cycle, while the start-glitch decision falls on tick 15 of the start bit. The driver task returns right after that tick. It then lets four more ticks of idle line pass, and the monitor samples on a falling edge inside that idle window, well after the results have settled and before the next start bit. Writes to the shared position and flag clears take effect one edge after the strobe, so they are read back on the following falling edge.

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd,
  input  logic          addr_en,
  input  logic          fe_sel,
  input  logic          pos7_we,
  input  logic          pos7_wd,
  output logic          pos7_rd,
  input  logic [DW-1:0] slave_addr,
  input  logic [DW-1:0] addr_mask,
  input  logic          rx_flag_clr,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit9,
  output logic          rx_flag,
  output logic          fe_flag
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2;
  localparam int BW  = $clog2(DW + 2);

  typedef enum logic [1:0] {IDLE, START, DATA, STOP} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [DW:0]   sh;
  logic [2:0]    smp;
  logic          mode9;

  wire maj     = (smp[0] & smp[1]) | (smp[0] & smp[2]) | (smp[1] & smp[2]);
  wire bit_end = tick && (cnt == CW'(OSR - 1));
  wire [DW-1:0] given = slave_addr & addr_mask;
  wire [DW-1:0] bcast = slave_addr | addr_mask;
  wire [DW-1:0] byte_in = sh[DW-1:0];
  wire hit    = ((byte_in & addr_mask) == given) || ((byte_in & bcast) == bcast);
  wire accept = maj && (!addr_en || (hit && (!mode9 || sh[DW])));
  wire [BW-1:0] last_bit = mode9 ? BW'(DW) : BW'(DW - 1);
  wire fe_clr = pos7_we && fe_sel && !pos7_wd;

  assign pos7_rd = fe_sel ? fe_flag : mode9;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; bitn <= '0; sh <= '0; smp <= '0;
      mode9 <= 1'b0; fe_flag <= 1'b0; rx_flag <= 1'b0;
      rx_data <= '0; rx_bit9 <= 1'b0;
    end else begin
      if (pos7_we && !fe_sel) mode9 <= pos7_wd;
      if (fe_clr) fe_flag <= 1'b0;
      if (rx_flag_clr) rx_flag <= 1'b0;
      if (tick) begin
        if (st == IDLE) begin
          cnt <= '0;
          if (!rxd) begin
            st <= START; cnt <= CW'(1); bitn <= '0; sh <= '0;
          end
        end else begin
          cnt <= cnt + 1'b1;
          if (cnt >= CW'(MID - 1) && cnt <= CW'(MID + 1)) smp <= {smp[1:0], rxd};
        end
      end
      if (bit_end) begin
        case (st)
          START: st <= maj ? IDLE : DATA;
          DATA: begin
            sh[bitn] <= maj;
            bitn <= bitn + 1'b1;
            if (bitn == last_bit) st <= STOP;
          end
          STOP: begin
            st <= IDLE;
            if (!maj) fe_flag <= 1'b1;
            if (accept) begin
              rx_flag <= 1'b1;
              rx_data <= byte_in;
              rx_bit9 <= mode9 & sh[DW];
            end
          end
          default: st <= IDLE;
        endcase
      end
    end
  end

  a_r3_addr_needs_bit9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_flag) && addr_en && mode9 |-> rx_bit9);

  a_r6_flag_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_flag) && addr_en |->
      ((rx_data & addr_mask) == (slave_addr & addr_mask)) ||
      ((rx_data & (slave_addr | addr_mask)) == (slave_addr | addr_mask)));

  a_r8_fe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fe_flag && !fe_clr |=> fe_flag);

  a_r10_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flag && !rx_flag_clr |=> rx_flag);

  a_r10_data_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> rx_flag);

  a_r2_start_only_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE) && tick && rxd |=> st == IDLE);
endmodule

// File: tb/tb_mp_uart_rx.sv
`timescale 1ns/1ps
module tb_mp_uart_rx;
  logic clk = 0, rst_n = 0, tick = 0, rxd = 1;
  logic addr_en = 0, fe_sel = 0, pos7_we = 0, pos7_wd = 0, rx_flag_clr = 0;
  logic [7:0] slave_addr = 0, addr_mask = 0;
  logic pos7_rd, rx_bit9, rx_flag, fe_flag;
  logic [7:0] rx_data;

  int total = 0, bad = 0;
  logic [10:0] expq[$];
  string reqq[$];
  logic [7:0] m_data = 0;
  logic m_b9 = 0, m_fe = 0;
  event frame_done;

  mp_uart_rx dut (.clk, .rst_n, .tick, .rxd, .addr_en, .fe_sel, .pos7_we, .pos7_wd,
    .pos7_rd, .slave_addr, .addr_mask, .rx_flag_clr, .rx_data, .rx_bit9, .rx_flag, .fe_flag);

  always #2.5 clk = ~clk;

  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    tick <= (tdiv == 0);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
  endtask

  task automatic put_bit(input logic v);
    @(negedge clk); rxd = v;
    wait_ticks(16);
  endtask

  task automatic pos7_write(input logic sel, input logic v);
    @(negedge clk); fe_sel = sel; pos7_we = 1; pos7_wd = v;
    @(negedge clk); pos7_we = 0;
  endtask

  task automatic clr_flag();
    @(negedge clk); rx_flag_clr = 1;
    @(negedge clk); rx_flag_clr = 0;
  endtask

  task automatic frame(input logic [8:0] val, input bit nine, input bit stop,
                       input bit acc, input string req);
    clr_flag();
    if (acc) begin m_data = val[7:0]; m_b9 = nine & val[8]; end
    if (!stop) m_fe = 1;
    expq.push_back({acc, m_fe, m_b9, m_data});
    reqq.push_back(req);
    put_bit(0);
    for (int i = 0; i < (nine ? 9 : 8); i++) put_bit(val[i]);
    put_bit(stop);
    @(negedge clk); rxd = 1;
    -> frame_done;
    wait_ticks(4);
  endtask

  initial begin : monitor
    forever begin
      logic [10:0] e;
      string r;
      @(frame_done);
      repeat (3) @(negedge clk);
      e = expq.pop_front();
      r = reqq.pop_front();
      check({rx_flag, fe_flag, rx_bit9, rx_data} == e, r,
            {rx_flag, fe_flag, rx_bit9, rx_data}, e);
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check({rx_flag, fe_flag, rx_bit9, rx_data, pos7_rd} == 0, "R1 reset", rx_data, 0);
    fe_sel = 1; @(negedge clk);
    check(pos7_rd == 0, "R1 fe read", pos7_rd, 0);
    fe_sel = 0;

    frame(9'h0A5, 0, 1, 1, "R10 plain 8-bit");
    frame(9'h13C, 0, 1, 1, "R10 plain 8-bit second");
    clr_flag();
    check(rx_flag == 0, "R10 clear", rx_flag, 0);

    pos7_write(0, 1);
    @(negedge clk);
    check(pos7_rd == 1, "R9 mode bit", pos7_rd, 1);
    frame(9'h15A, 1, 1, 1, "R10 plain 9-bit");

    slave_addr = 8'hC0; addr_mask = 8'hFD; addr_en = 1;
    frame(9'h1C2, 1, 1, 1, "R4 given hit 9-bit");
    frame(9'h1C1, 1, 1, 0, "R4 given miss 9-bit");
    frame(9'h0C2, 1, 1, 0, "R3 ninth bit 0");
    frame(9'h1FF, 1, 1, 1, "R5 broadcast hit");
    slave_addr = 8'h30; addr_mask = 8'h0C;
    frame(9'h13C, 1, 1, 1, "R5 broadcast exact");
    frame(9'h138, 1, 1, 0, "R5 broadcast miss");

    pos7_write(0, 0);
    slave_addr = 8'hC0; addr_mask = 8'hFD;
    frame(9'h0C2, 0, 1, 1, "R6 8-bit hit");
    frame(9'h0C1, 0, 1, 0, "R6 8-bit miss");
    slave_addr = 0; addr_mask = 0;
    frame(9'h037, 0, 1, 1, "R7 zero regs");

    addr_en = 0;
    frame(9'h066, 0, 0, 0, "R8 bad stop");
    fe_sel = 1; @(negedge clk);
    check(pos7_rd == 1, "R9 fe read", pos7_rd, 1);
    pos7_write(1, 1);
    @(negedge clk);
    check(fe_flag == 1, "R8 write 1 keeps", fe_flag, 1);
    pos7_write(1, 0);
    @(negedge clk);
    check(fe_flag == 0, "R8 write 0 clears", fe_flag, 0);
    m_fe = 0;
    fe_sel = 0;

    clr_flag();
    @(negedge clk); rxd = 0;
    wait_ticks(4);
    @(negedge clk); rxd = 1;
    wait_ticks(24);
    check(rx_flag == 0 && rx_data == 8'h37, "R2 glitch ignored", {rx_flag, rx_data}, 8'h37);
    frame(9'h081, 0, 1, 1, "R2 frame after glitch");

    repeat (20) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule